// File: doc/BRIEF.md
# Eight-bit shift rotate flag unit

This block is the shift and rotate slice of a small processor's execution stage. Each accepted request carries one register operand, the processor's present CARRY flag and a 3-bit operation select. One clock edge later the block presents the shifted result, the new CARRY, the new ZERO and a write-enable. The register file and the flag register use these outputs to commit the operation.

Eight operations are covered. Each moves the operand one place left or right. The operations differ in what enters the vacated end: a constant 0, a constant 1, a copy of an operand edge bit, or the incoming CARRY. The bit pushed out of the far end always becomes the new CARRY. ZERO is taken from the result. While the request strobe is low, every output keeps its last value.

Top module: `shrot_unit`

## Requirements
- R1: While reset is asserted, and until the first accepted request after it, result_o, carry_o, zero_o and wr_en_o are all 0.
- R2: Bit 0 of op_i selects the direction: 0 means left and 1 means right. A left operation produces {operand[6:0], fill} and sets the new CARRY to operand[7]. A right operation produces {fill, operand[7:1]} and sets the new CARRY to operand[0].
- R3: Codes 0 (left) and 1 (right) use a fill bit of 0.
- R4: Codes 2 (left) and 3 (right) use a fill bit of 1, so zero_o is always 0 after either of them.
- R5: Code 4 (left) uses operand[0] as the fill bit. Code 5 (right) uses operand[7] as the fill bit, so the sign bit is kept.
- R6: Codes 6 (left) and 7 (right) use the incoming carry_i as the fill bit.
- R7: After every accepted request, zero_o is 1 exactly when the new result_o equals 0x00.
- R8: A request with valid_i high at a rising clock edge appears on result_o, carry_o and zero_o after that same edge, and wr_en_o goes to 1.
- R9: At an edge where valid_i is low, result_o, carry_o, zero_o and wr_en_o keep their values, whatever op_i, operand_i and carry_i are doing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation select |
| operand_i | input | WIDTH | Register operand |
| carry_i | input | 1 | Current CARRY flag |
| result_o | output | WIDTH | Shifted result |
| carry_o | output | 1 | New CARRY flag |
| zero_o | output | 1 | New ZERO flag |
| wr_en_o | output | 1 | Write-enable for the register file and flags |

## Verification
The bench builds the unit at its default WIDTH of 8. At that width the input space is small enough to sweep completely: every one of the eight codes is applied with all 256 operand values and with both carry_i values. Every edge case is therefore reached, including all-zero results, a one-fill on the operand 0x00, and both signs under the extension shifts. Separate sequences hold valid_i low while the other inputs change, to show that the outputs do not move.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  localparam int OP_W = 3;

  typedef enum logic [1:0] {
    FILL_ZERO  = 2'b00,
    FILL_ONE   = 2'b01,
    FILL_EDGE  = 2'b10,
    FILL_CARRY = 2'b11
  } fill_kind_e;

  typedef enum logic [OP_W-1:0] {
    OP_SHL_ZERO  = 3'd0,
    OP_SHR_ZERO  = 3'd1,
    OP_SHL_ONE   = 3'd2,
    OP_SHR_ONE   = 3'd3,
    OP_SHL_EDGE  = 3'd4,
    OP_SHR_EDGE  = 3'd5,
    OP_SHL_CARRY = 3'd6,
    OP_SHR_CARRY = 3'd7
  } shrot_op_e;

  function automatic fill_kind_e op_fill(input logic [OP_W-1:0] op);
    return fill_kind_e'(op[2:1]);
  endfunction

  function automatic logic op_right(input logic [OP_W-1:0] op);
    return op[0];
  endfunction
endpackage

// File: rtl/shrot_fill.sv
module shrot_fill
  import shrot_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  fill_kind_e       kind_i,
  input  logic             right_i,
  input  logic [WIDTH-1:0] operand_i,
  input  logic             carry_i,
  output logic             fill_o
);
  localparam int MSB = WIDTH - 1;

  logic edge_bit;

  always_comb begin
    edge_bit = right_i ? operand_i[MSB] : operand_i[0];
    unique case (kind_i)
      FILL_ZERO:  fill_o = 1'b0;
      FILL_ONE:   fill_o = 1'b1;
      FILL_EDGE:  fill_o = edge_bit;
      FILL_CARRY: fill_o = carry_i;
      default:    fill_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/shrot_shift.sv
module shrot_shift #(
  parameter int WIDTH = 8
) (
  input  logic             right_i,
  input  logic             fill_i,
  input  logic [WIDTH-1:0] operand_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o
);
  localparam int MSB = WIDTH - 1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic from_low;
    logic from_high;
    if (i == 0) begin : g_lo_end
      assign from_low = fill_i;
    end else begin : g_lo_mid
      assign from_low = operand_i[i-1];
    end
    if (i == MSB) begin : g_hi_end
      assign from_high = fill_i;
    end else begin : g_hi_mid
      assign from_high = operand_i[i+1];
    end
    assign result_o[i] = right_i ? from_high : from_low;
  end

  assign carry_o = right_i ? operand_i[0] : operand_i[MSB];
endmodule

// File: rtl/shrot_zero.sv
module shrot_zero #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] value_i,
  output logic             zero_o
);
  logic [WIDTH:0] acc;

  assign acc[0] = 1'b0;
  for (genvar i = 0; i < WIDTH; i++) begin : g_or
    assign acc[i+1] = acc[i] | value_i[i];
  end
  assign zero_o = ~acc[WIDTH];
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [WIDTH-1:0] operand_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             zero_o,
  output logic             wr_en_o
);
  localparam int MSB = WIDTH - 1;

  // Reset: asserts at once, releases two edges after rst_n rises.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Combinational datapath
  logic             fill_bit;
  logic [WIDTH-1:0] shift_res;
  logic             shift_cy;
  logic             res_zero;

  shrot_fill #(.WIDTH(WIDTH)) u_fill (
    .kind_i    (op_fill(op_i)),
    .right_i   (op_right(op_i)),
    .operand_i (operand_i),
    .carry_i   (carry_i),
    .fill_o    (fill_bit)
  );

  shrot_shift #(.WIDTH(WIDTH)) u_shift (
    .right_i   (op_right(op_i)),
    .fill_i    (fill_bit),
    .operand_i (operand_i),
    .result_o  (shift_res),
    .carry_o   (shift_cy)
  );

  shrot_zero #(.WIDTH(WIDTH)) u_zero (
    .value_i (shift_res),
    .zero_o  (res_zero)
  );

  // Next state
  logic [WIDTH-1:0] res_d, res_q;
  logic             cy_d, cy_q, z_d, z_q, we_d, we_q;
  logic             upd_en;

  always_comb begin
    upd_en = valid_i;
    res_d  = res_q;
    cy_d   = cy_q;
    z_d    = z_q;
    we_d   = we_q;
    if (upd_en) begin
      res_d = shift_res;
      cy_d  = shift_cy;
      z_d   = res_zero;
      we_d  = 1'b1;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_q <= '0;
      cy_q  <= 1'b0;
      z_q   <= 1'b0;
      we_q  <= 1'b0;
    end else begin
      res_q <= res_d;
      cy_q  <= cy_d;
      z_q   <= z_d;
      we_q  <= we_d;
    end
  end

  assign result_o = res_q;
  assign carry_o  = cy_q;
  assign zero_o   = z_q;
  assign wr_en_o  = we_q;

  // Assertions
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !valid_i |=> ($stable(result_o) && $stable(carry_o) && $stable(zero_o) && $stable(wr_en_o)));

  assert_wren_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    valid_i |=> wr_en_o);

  assert_one_fill_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (valid_i && op_i[2:1] == 2'b01) |=> !zero_o);

  assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_en_o |-> (zero_o == (result_o == '0)));

  assert_left_carry_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (valid_i && !op_i[0]) |=> (carry_o == $past(operand_i[MSB])));

  assert_right_carry_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (valid_i && op_i[0]) |=> (carry_o == $past(operand_i[0])));

  assert_sign_keep_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (valid_i && op_i == 3'd5) |=> (result_o[MSB] == $past(operand_i[MSB])));

  assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !wr_en_o |-> (result_o == '0 && !carry_o && !zero_o));
endmodule

// File: tb/sim_shrot_unit.sv
module sim_shrot_unit;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         valid_i;
  logic [2:0]   op_i;
  logic [W-1:0] operand_i;
  logic         carry_i;
  logic [W-1:0] result_o;
  logic         carry_o, zero_o, wr_en_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  shrot_unit #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
    .operand_i(operand_i), .carry_i(carry_i), .result_o(result_o),
    .carry_o(carry_o), .zero_o(zero_o), .wr_en_o(wr_en_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string req_of(input int op);
    case (op)
      0, 1:    return "R3";
      2, 3:    return "R4";
      4, 5:    return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic run_op(input int op, input int a, input int c);
    int fill, res, cy;
    case (op / 2)
      0: fill = 0;
      1: fill = 1;
      2: fill = (op % 2 == 1) ? (a / 128) % 2 : a % 2;
      default: fill = c;
    endcase
    if (op % 2 == 0) begin
      res = (a * 2 + fill) % 256;
      cy  = (a / 128) % 2;
    end else begin
      res = a / 2 + fill * 128;
      cy  = a % 2;
    end
    valid_i   = 1'b1;
    op_i      = 3'(op);
    operand_i = 8'(a);
    carry_i   = c[0];
    @(negedge clk);
    check(req_of(op), int'(result_o), res);
    check("R2", int'(carry_o), cy);
    check("R7", int'(zero_o), (res == 0) ? 1 : 0);
    check("R8", int'(wr_en_o), 1);
  endtask

  initial begin
    rst_n = 1'b0; valid_i = 1'b0; op_i = '0; operand_i = '0; carry_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", int'(result_o), 0);
    check("R1", int'(wr_en_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", int'(result_o), 0);
    check("R1", int'(carry_o), 0);
    check("R1", int'(zero_o), 0);
    check("R1", int'(wr_en_o), 0);

    for (int op = 0; op < 8; op++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < 256; a++)
          run_op(op, a, c);

    // R9: hold while valid_i is low, with changing inputs
    run_op(1, 8'h01, 0);
    valid_i = 1'b0;
    for (int k = 0; k < 8; k++) begin
      op_i = 3'(k); operand_i = 8'(k * 37 + 5); carry_i = k[0];
      @(negedge clk);
      check("R9", int'(result_o), 0);
      check("R9", int'(zero_o), 1);
      check("R9", int'(carry_o), 1);
      check("R9", int'(wr_en_o), 1);
    end
    run_op(2, 8'hA5, 0);
    valid_i = 1'b0; op_i = 3'd0; operand_i = 8'h00;
    repeat (2) @(negedge clk);
    check("R9", int'(result_o), 8'h4B);
    check("R9", int'(carry_o), 1);
    check("R9", int'(zero_o), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule